// File: doc/BRIEF.md
# TDM Channel Output-Enable Serializer

This block drives two serial control lines that tell the external buffers of a time-division-multiplexed output port which channels to drive and which to leave at high impedance. Each of 16 output streams has one enable bit per channel. A bit value of 1 means the channel is driven and 0 means the channel is high impedance. Each stream also has its own data rate of 16, 8, 4 or 2 Mb/s. Line 0 serves the even streams and line 1 serves the odd streams.

Both lines always emit one bit per period of the 16.384 MHz output clock. A frame is 2048 periods long. Within every group of eight periods, each stream owns one fixed slot. The bit for a channel is sent ahead of the channel itself, and it is repeated in every slot the channel covers: once at 16 Mb/s and up to eight times at 2 Mb/s.

The enable bits and the rate codes are loaded through a plain synchronous write port. A change to either one is applied only at a channel boundary, so a channel in progress never shows a mix of old and new values.

Top module: `tdm_oe_serializer`

## Requirements
- R1: While `rst` is high, both bits of `cst_o` read 0.
- R2: When `fp_i` is sampled high at a clock edge, the next clock period is frame period 0. Without a pulse, the period number counts up by one per clock and wraps from 2047 to 0.
- R3: In frame period p, let q = (p + 10) mod 2048. Line L (bit L of `cst_o`) then carries stream 2·(q mod 8) + L. Line 0 therefore only ever shows even streams and line 1 only odd streams.
- R4: The channel-0 bit of stream 0 is sent in period 2038 on line 0. The channel-0 bits of streams 14 and 15 are sent in period 2045, on lines 0 and 1 respectively.
- R5: Rate codes are 0 for 16 Mb/s, 1 for 8 Mb/s, 2 for 4 Mb/s and 3 for 2 Mb/s. A stream with code r shows channel (q div 8) >> r. Each channel bit therefore appears 2^r times, with successive appearances eight periods apart.
- R6: A 2 Mb/s stream 4 shows its channel-0 bit in periods 2040, 0, 8, 16, 24, 32, 40 and 48, and shows channel 1 from period 56.
- R7: A write with `en_we_i` high stores `en_bit_i` for stream `en_stream_i`, channel `en_chan_i`. Once the stream's channel restarts, the line shows the stored bit: 1 means drive the channel, 0 means high impedance.
- R8: An enable bit is fetched at the first appearance of its channel, and the later repeats reuse that fetched value. A write made in the middle of a channel does not change the remaining repeats, and it shows from the next start of that channel.
- R9: A rate write (`rate_we_i`, `rate_stream_i`, `rate_code_i`) is held pending. The stream adopts it at its first slot in which (q div 8) mod 8 = 0. Until then, the stream keeps its old channel numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz output clock |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse; the next period is period 0 |
| en_we_i | input | 1 | Enable-bit write strobe |
| en_stream_i | input | 4 | Stream to write; bit 0 selects the line |
| en_chan_i | input | 8 | Channel to write (16 Mb/s numbering) |
| en_bit_i | input | 1 | Enable value: 1 drive, 0 high impedance |
| rate_we_i | input | 1 | Rate write strobe |
| rate_stream_i | input | 4 | Stream whose rate is written |
| rate_code_i | input | 2 | Rate code (0=16, 1=8, 2=4, 3=2 Mb/s) |
| cst_o | output | 2 | Serial control lines: bit 0 even streams, bit 1 odd streams |

## Verification
The hardest situation to reach is a write that lands partway through a channel: while an earlier fetch is still being repeated, or just before a rate boundary. The stimulus follows the period number of the line and times its writes to a known period. It rewrites the channel-0 bit of a 2 Mb/s stream between its third and fourth repeats. It also changes a stream's rate two slots before an aligned boundary, with the enable bits chosen so that the old and the new channel numbering give different values. Randomized frames that mix all four rates, including one after a mid-frame frame pulse, are compared bit by bit against a model of the slot mapping.

// File: rtl/toe_pkg.sv
package toe_pkg;

  localparam int unsigned RATE_W = 2;
  // slowest rate repeats a channel 2^(2^RATE_W - 1) times; boundaries of all rates align there
  localparam int unsigned ALIGN_W = (1 << RATE_W) - 1;

  typedef enum logic [RATE_W-1:0] {
    REP_X1 = 2'd0,
    REP_X2 = 2'd1,
    REP_X4 = 2'd2,
    REP_X8 = 2'd3
  } rep_code_e;

endpackage

// File: rtl/toe_period_counter.sv
module toe_period_counter #(
  parameter int unsigned PERIOD_W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fp_i,
  output logic [PERIOD_W-1:0] cnt_o
);

  logic [PERIOD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || fp_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_FP_RESTART: assert property (@(posedge clk) disable iff (rst)
    fp_i |=> (cnt_q == '0)) else $error("frame pulse did not restart count"); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !fp_i |=> (cnt_q == $past(cnt_q) + 1'b1)) else $error("period count skipped"); // R2

endmodule

// File: rtl/toe_enable_ram.sv
module toe_enable_ram #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/toe_line.sv
module toe_line #(
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned CHAN_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sync_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [CHAN_W-1:0]          win_i,
  input  logic                       en_we_i,
  input  logic [SLOT_W+CHAN_W-1:0]   en_addr_i,
  input  logic                       en_bit_i,
  input  logic                       rate_we_i,
  input  logic [SLOT_W-1:0]          rate_slot_i,
  input  logic [toe_pkg::RATE_W-1:0] rate_code_i,
  output logic                       cst_o
);
  import toe_pkg::*;

  localparam int unsigned NSLOT    = 1 << SLOT_W;
  localparam int unsigned ADDR_W   = SLOT_W + CHAN_W;
  localparam int unsigned WARM_MIN = NSLOT + 4;

  rep_code_e pend_q [NSLOT];
  rep_code_e act_q  [NSLOT];
  rep_code_e rate_cur;
  logic              aligned;
  logic              first_s0;
  logic [CHAN_W-1:0] chan_s0;
  logic [CHAN_W-1:0] rep_mask;

  // stage 0: channel and first-appearance decode
  assign aligned  = (win_i[ALIGN_W-1:0] == '0);
  assign rate_cur = aligned ? pend_q[slot_i] : act_q[slot_i];
  assign rep_mask = ~({CHAN_W{1'b1}} << rate_cur);
  assign first_s0 = ((win_i & rep_mask) == '0);
  assign chan_s0  = win_i >> rate_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) pend_q[i] <= REP_X1;
    end else if (rate_we_i) begin
      pend_q[rate_slot_i] <= rep_code_e'(rate_code_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) act_q[i] <= REP_X1;
    end else if (aligned) begin
      act_q[slot_i] <= pend_q[slot_i];
    end
  end

  logic rd_bit;

  toe_enable_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .we_i    (en_we_i),
    .waddr_i (en_addr_i),
    .wdata_i (en_bit_i),
    .raddr_i ({slot_i, chan_s0}),
    .rdata_o (rd_bit)
  );

  // stage 1: fetched bit or repeat of the held one
  logic              first_q;
  logic [SLOT_W-1:0] slot_q;
  logic              hold_q [NSLOT];
  logic              bit_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      slot_q  <= '0;
    end else begin
      first_q <= first_s0;
      slot_q  <= slot_i;
    end
  end

  assign bit_s1 = first_q ? rd_bit : hold_q[slot_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) hold_q[i] <= 1'b0;
      cst_o <= 1'b0;
    end else begin
      hold_q[slot_q] <= bit_s1;
      cst_o          <= bit_s1;
    end
  end

  // cycles since reset or resync, gating checks that look back one slot group
  logic [$clog2(WARM_MIN+1)-1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst || sync_i)                   warm_q <= '0;
    else if (warm_q != WARM_MIN[$bits(warm_q)-1:0]) warm_q <= warm_q + 1'b1;
  end

  AST_REPEAT_HOLD: assert property (@(posedge clk)
    disable iff (rst || (warm_q != WARM_MIN[$bits(warm_q)-1:0]))
    !first_q |=> (cst_o == $past(cst_o, NSLOT))) else $error("repeat differs from first bit"); // R8

  for (genvar j = 0; j < NSLOT; j++) begin : g_adopt_chk
    AST_RATE_ADOPT: assert property (@(posedge clk) disable iff (rst)
      !(aligned && (slot_i == SLOT_W'(j))) |=> $stable(act_q[j])) else $error("rate adopted off boundary"); // R9
  end

endmodule

// File: rtl/tdm_oe_serializer.sv
module tdm_oe_serializer #(
  parameter int unsigned PERIOD_W = 11,
  parameter int unsigned SLOT_W   = 3,
  parameter int unsigned ADVANCE  = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fp_i,
  input  logic                         en_we_i,
  input  logic [SLOT_W:0]              en_stream_i,
  input  logic [PERIOD_W-SLOT_W-1:0]   en_chan_i,
  input  logic                         en_bit_i,
  input  logic                         rate_we_i,
  input  logic [SLOT_W:0]              rate_stream_i,
  input  logic [toe_pkg::RATE_W-1:0]   rate_code_i,
  output logic [1:0]                   cst_o
);

  localparam int unsigned CHAN_W  = PERIOD_W - SLOT_W;
  localparam int unsigned PIPE    = 2;            // lookup stage + output register
  localparam int unsigned LEAD    = ADVANCE + PIPE;
  localparam int unsigned N_LINES = 2;

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W-1:0] lead;

  toe_period_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .fp_i  (fp_i),
    .cnt_o (cnt)
  );

  assign lead = cnt + PERIOD_W'(LEAD);

  for (genvar ln = 0; ln < N_LINES; ln++) begin : g_line
    toe_line #(.SLOT_W(SLOT_W), .CHAN_W(CHAN_W)) u_line (
      .clk         (clk),
      .rst         (rst),
      .sync_i      (fp_i),
      .slot_i      (lead[SLOT_W-1:0]),
      .win_i       (lead[PERIOD_W-1:SLOT_W]),
      .en_we_i     (en_we_i && (en_stream_i[0] == 1'(ln))),
      .en_addr_i   ({en_stream_i[SLOT_W:1], en_chan_i}),
      .en_bit_i    (en_bit_i),
      .rate_we_i   (rate_we_i && (rate_stream_i[0] == 1'(ln))),
      .rate_slot_i (rate_stream_i[SLOT_W:1]),
      .rate_code_i (rate_code_i),
      .cst_o       (cst_o[ln])
    );
  end

endmodule

// File: tb/tdm_oe_serializer_tb.sv
`timescale 1ns/1ps
module tdm_oe_serializer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp = 1'b0;
  logic       en_we = 1'b0;
  logic [3:0] en_stream = '0;
  logic [7:0] en_chan = '0;
  logic       en_bit = 1'b0;
  logic       rate_we = 1'b0;
  logic [3:0] rate_stream = '0;
  logic [1:0] rate_code = '0;
  logic [1:0] cst;

  int n_chk = 0;
  int n_err = 0;
  int per = 0;
  bit done = 0;
  bit en_m [16][256];
  int rate_m [16];

  always #4 clk = ~clk;

  tdm_oe_serializer u_dut (
    .clk(clk), .rst(rst), .fp_i(fp),
    .en_we_i(en_we), .en_stream_i(en_stream), .en_chan_i(en_chan), .en_bit_i(en_bit),
    .rate_we_i(rate_we), .rate_stream_i(rate_stream), .rate_code_i(rate_code),
    .cst_o(cst)
  );

  // frame period seen by the bench (R2)
  always @(posedge clk) per <= fp ? 0 : (per + 1) % 2048;

  function automatic bit exp_bit(int p, int ln, int r);
    int q, s;
    q = (p + 10) % 2048;
    s = 2 * (q % 8) + ln;
    return en_m[s][(q / 8) >> r];
  endfunction

  function automatic int stream_of(int p, int ln);
    return 2 * (((p + 10) % 2048) % 8) + ln;
  endfunction

  task automatic chk(input logic act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %0b (period %0d)", tag, act, exp, per);
    end
  endtask

  task automatic wr_en(int s, int c, bit b);
    en_we = 1'b1; en_stream = 4'(s); en_chan = 8'(c); en_bit = b;
    @(negedge clk);
    en_we = 1'b0;
    en_m[s][c] = b;
  endtask

  task automatic wr_rate(int s, int r);
    rate_we = 1'b1; rate_stream = 4'(s); rate_code = 2'(r);
    @(negedge clk);
    rate_we = 1'b0;
    rate_m[s] = r;
  endtask

  task automatic pulse_fp();
    fp = 1'b1;
    @(negedge clk);
    fp = 1'b0;
  endtask

  task automatic wait_period(int p);
    @(negedge clk);
    while (per != p) @(negedge clk);
  endtask

  task automatic check_frame(int nper);
    for (int i = 0; i < nper; i++) begin
      for (int ln = 0; ln < 2; ln++)
        chk(cst[ln], exp_bit(per, ln, rate_m[stream_of(per, ln)]), "R3 R5 R7 frame compare");
      @(negedge clk);
    end
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(cst[0], 1'b0, "R1 reset line0");
    chk(cst[1], 1'b0, "R1 reset line1");
    rst = 1'b0;
    @(negedge clk);
    pulse_fp();

    // randomized frames with mixed rates
    for (int rnd = 0; rnd < 3; rnd++) begin
      for (int s = 0; s < 16; s++) wr_rate(s, (rnd == 0) ? 0 : int'($urandom % 4));
      for (int s = 0; s < 16; s++)
        for (int c = 0; c < 256; c++) wr_en(s, c, 1'($urandom % 2));
      repeat (150) @(negedge clk);
      if (rnd == 1) begin
        pulse_fp();   // mid-frame resync, R2
        repeat (150) @(negedge clk);
      end
      wait_period(0);
      check_frame(2048);
    end

    // R4: channel-0 placement of streams 0, 14, 15
    for (int s = 0; s < 16; s++) wr_rate(s, 0);
    wr_en(0, 0, 1); wr_en(0, 1, 0); wr_en(0, 255, 0);
    wr_en(14, 0, 1); wr_en(14, 1, 0);
    wr_en(15, 0, 1); wr_en(15, 255, 0);
    repeat (150) @(negedge clk);
    wait_period(2030); chk(cst[0], 1'b0, "R4 stream0 ch255");
    wait_period(2037); chk(cst[1], 1'b0, "R4 stream15 ch255");
    wait_period(2038); chk(cst[0], 1'b1, "R4 stream0 ch0");
    wait_period(2045); chk(cst[0], 1'b1, "R4 stream14 ch0");
                       chk(cst[1], 1'b1, "R4 stream15 ch0");
    wait_period(2046); chk(cst[0], 1'b0, "R4 stream0 ch1");
    wait_period(5);    chk(cst[0], 1'b0, "R4 stream14 ch1");

    // R6: 2 Mb/s stream 4 repeats
    wr_rate(4, 3);
    wr_en(4, 0, 1); wr_en(4, 1, 0);
    repeat (150) @(negedge clk);
    wait_period(2040); chk(cst[0], 1'b1, "R6 stream4 ch0 at 2040");
    for (int p = 0; p <= 48; p += 8) begin
      wait_period(p); chk(cst[0], 1'b1, "R6 stream4 ch0 repeat");
    end
    wait_period(56); chk(cst[0], 1'b0, "R6 stream4 ch1 start");

    // R8: mid-channel rewrite keeps the remaining repeats
    wait_period(16);
    chk(cst[0], 1'b1, "R8 before rewrite");
    wr_en(4, 0, 0);
    for (int p = 24; p <= 48; p += 8) begin
      wait_period(p); chk(cst[0], 1'b1, "R8 repeats keep old bit");
    end
    wait_period(2040); chk(cst[0], 1'b0, "R8 new bit at next channel start");

    // R9: rate change adopted only at aligned boundary (stream 1, line 1)
    wr_rate(1, 0);
    wr_en(1, 102, 1); wr_en(1, 103, 0); wr_en(1, 104, 1);
    wr_en(1, 12, 1);  wr_en(1, 13, 0);
    repeat (150) @(negedge clk);
    wait_period(800);
    wr_rate(1, 3);
    wait_period(806); chk(cst[1], 1'b1, "R9 old rate w102");
    wait_period(814); chk(cst[1], 1'b0, "R9 old rate w103");
    wait_period(822); chk(cst[1], 1'b0, "R9 new rate adopted at w104");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule